// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside a shared target memory and watches read/write traffic so that masters can build atomic read-modify-write sequences without locking the bus. A master opens a reservation with an exclusive read. The monitor records the transaction ID, start address and transfer size of that read in one of a fixed number of entries. When the same ID later issues an exclusive write, the monitor decides in the same cycle whether the write may reach memory. It reports the outcome as a two-bit response code.

A reservation is lost when any committed write touches its bytes. A committed write is either a normal write or a successful exclusive write, from any master. A reservation is also lost when its ID opens a newer reservation, or when the entry is reclaimed to make room for a new ID. Byte ranges are compared by overlap, so a write that only partly covers a reserved range still breaks the reservation.

Top module: `excl_monitor`

## Requirements
- R1: After reset no reservation exists. An exclusive write then returns OKAY (2'b00) with `wr_mem_en` low.
- R2: An exclusive write succeeds, giving `wr_resp` = EXOKAY (2'b01) and `wr_mem_en` high in the cycle it is presented, when its ID holds a live entry with exactly the same address and size code. The byte count is 2**size.
- R3: A failed exclusive write returns OKAY with `wr_mem_en` low and leaves every entry unchanged.
- R4: A successful exclusive write frees every entry whose byte range overlaps it, including entries owned by other IDs.
- R5: A normal write always gives `wr_mem_en` high and OKAY, and it frees every overlapping entry.
- R6: An ID owns at most one entry. A new exclusive read from that ID replaces its old reservation.
- R7: With N_ENT entries, N_ENT distinct IDs can hold reservations on disjoint ranges at the same time, and every one of their exclusive writes succeeds.
- R8: A new ID arriving while all entries are live reclaims the least recently allocated entry. A free entry is used instead when one exists. Replacing an ID's own entry counts as a fresh allocation.
- R9: A write breaks a reservation exactly when their byte ranges overlap; adjacent ranges do not.
- R10: A successful exclusive write also frees the writer's own entry, so repeating it fails.
- R11: If an exclusive read and a clearing write arrive in the same cycle, the clear is applied first and the new reservation survives.
- R12: Non-exclusive reads and idle cycles change no entry. `wr_resp` is OKAY when `wr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request present this cycle |
| rd_id | input | ID_W | Read transaction ID |
| rd_addr | input | ADDR_W | Read start byte address |
| rd_size | input | SIZE_W | Read size code, bytes = 2**size |
| rd_excl | input | 1 | Read is exclusive |
| wr_valid | input | 1 | Write request present this cycle |
| wr_id | input | ID_W | Write transaction ID |
| wr_addr | input | ADDR_W | Write start byte address |
| wr_size | input | SIZE_W | Write size code, bytes = 2**size |
| wr_excl | input | 1 | Write is exclusive |
| wr_mem_en | output | 1 | Write may update memory (combinational) |
| wr_resp | output | 2 | 2'b00 OKAY, 2'b01 EXOKAY (combinational) |

## Verification
The embedded properties are checked on every cycle. They cover: failed exclusive writes never enabling memory, EXOKAY appearing only for exclusive writes, normal writes always committing with OKAY, no two live entries sharing an ID, exactly one slot chosen per allocation, and an exclusive read leaving a live entry for its ID in the next cycle. Some behaviours can only be shown by bench scenarios that compare later write outcomes against the expected history. These are: which entry is reclaimed under pressure, whether a partial overlap breaks a reservation, cross-master invalidation, and replacement of an ID's reservation. The bench sweeps write offsets around a reserved range, and it fills and overflows the entry pool.

// File: rtl/xm_pkg.sv
package xm_pkg;

    typedef enum logic [1:0] {
        XM_OKAY   = 2'b00,
        XM_EXOKAY = 2'b01
    } xm_resp_e;

endpackage

// File: rtl/xm_range_cmp.sv
module xm_range_cmp #(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 3
) (
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [SIZE_W-1:0] a_size,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [SIZE_W-1:0] b_size,
    output logic              overlap,
    output logic              same
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_lo    = {1'b0, a_addr};
        b_lo    = {1'b0, b_addr};
        a_hi    = a_lo + (EXT_W'(1) << a_size);
        b_hi    = b_lo + (EXT_W'(1) << b_size);
        overlap = (a_lo < b_hi) && (b_lo < a_hi);
        same    = (a_addr == b_addr) && (a_size == b_size);
    end

endmodule

// File: rtl/xm_slot_pick.sv
module xm_slot_pick #(
    parameter int N_ENT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic [N_ENT-1:0]            own,
    input  logic [N_ENT-1:0]            free,
    input  logic [N_ENT-1:0][N_ENT-1:0] older,
    output logic [N_ENT-1:0]            pick
);
    logic [N_ENT-1:0] oldest;
    logic [N_ENT-1:0] first_free;

    for (genvar i = 0; i < N_ENT; i++) begin : g_age
        logic [N_ENT-1:0] self_bit;
        assign self_bit  = N_ENT'(1) << i;
        assign oldest[i] = &(older[i] | self_bit);
    end

    always_comb begin
        first_free = free & (~free + N_ENT'(1));
        if (|own)
            pick = own;
        else if (|free)
            pick = first_free;
        else
            pick = oldest;
    end

    p_slot_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ($countones(pick) == 1));

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import xm_pkg::*;
#(
    parameter int N_ENT  = 4,
    parameter int ID_W   = 4,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ID_W-1:0]   rd_id,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [SIZE_W-1:0] rd_size,
    input  logic              rd_excl,
    input  logic              wr_valid,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic              wr_excl,
    output logic              wr_mem_en,
    output logic [1:0]        wr_resp
);
    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
    } ent_t;

    typedef struct packed {
        logic [N_ENT-1:0]            vld;
        ent_t [N_ENT-1:0]            ent;
        logic [N_ENT-1:0][N_ENT-1:0] older;
    } st_t;

    st_t st_q, st_d;

    logic [N_ENT-1:0] wr_ov, wr_eq, wr_own, rd_own;
    logic [N_ENT-1:0] clr, free_after, pick;
    logic             excl_ok, alloc;

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        xm_range_cmp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_cmp (
            .a_addr  (st_q.ent[i].addr),
            .a_size  (st_q.ent[i].size),
            .b_addr  (wr_addr),
            .b_size  (wr_size),
            .overlap (wr_ov[i]),
            .same    (wr_eq[i])
        );
        assign wr_own[i] = st_q.vld[i] && (st_q.ent[i].id == wr_id) && wr_eq[i];
        assign rd_own[i] = st_q.vld[i] && (st_q.ent[i].id == rd_id);
    end

    always_comb begin
        excl_ok   = wr_valid && wr_excl && (|wr_own);
        wr_mem_en = wr_valid && (!wr_excl || excl_ok);
        wr_resp   = excl_ok ? XM_EXOKAY : XM_OKAY;
        clr        = wr_mem_en ? (wr_ov & st_q.vld) : '0;
        free_after = ~(st_q.vld & ~clr);
        alloc      = rd_valid && rd_excl;
    end

    xm_slot_pick #(.N_ENT(N_ENT)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (alloc),
        .own   (rd_own),
        .free  (free_after),
        .older (st_q.older),
        .pick  (pick)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = st_q.vld & ~clr;
        if (alloc) begin
            for (int k = 0; k < N_ENT; k++) begin
                if (pick[k]) begin
                    st_d.vld[k]      = 1'b1;
                    st_d.ent[k].id   = rd_id;
                    st_d.ent[k].addr = rd_addr;
                    st_d.ent[k].size = rd_size;
                    for (int j = 0; j < N_ENT; j++) begin
                        if (j != k) begin
                            st_d.older[k][j] = 1'b0;
                            st_d.older[j][k] = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld <= '0;
            st_q.ent <= '0;
            for (int i = 0; i < N_ENT; i++)
                for (int j = 0; j < N_ENT; j++)
                    st_q.older[i][j] <= (i < j);
        end else begin
            st_q <= st_d;
        end
    end

    // Checker state: remembers the last exclusive read for R11
    logic            chk_fire_q;
    logic [ID_W-1:0] chk_id_q;
    logic            chk_live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_fire_q <= 1'b0;
            chk_id_q   <= '0;
        end else begin
            chk_fire_q <= alloc;
            chk_id_q   <= rd_id;
        end
    end

    always_comb begin
        chk_live = 1'b0;
        for (int i = 0; i < N_ENT; i++)
            if (st_q.vld[i] && st_q.ent[i].id == chk_id_q)
                chk_live = 1'b1;
    end

    p_alloc_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fire_q |-> chk_live);

    p_fail_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_excl && wr_resp == XM_OKAY) |-> !wr_mem_en);

    p_exok_excl_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_resp == XM_EXOKAY) |-> (wr_valid && wr_excl && wr_mem_en));

    p_normal_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_excl) |-> (wr_mem_en && wr_resp == XM_OKAY));

    p_idle_okay_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> (!wr_mem_en && wr_resp == XM_OKAY));

    for (genvar i = 0; i < N_ENT; i++) begin : g_uniq
        for (genvar j = i + 1; j < N_ENT; j++) begin : g_pair
            p_one_per_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !(st_q.vld[i] && st_q.vld[j] && st_q.ent[i].id == st_q.ent[j].id));
        end
    end

endmodule

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;
    localparam int N_ENT = 4, ID_W = 4, ADDR_W = 16, SIZE_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_valid = 0, rd_excl = 0, wr_valid = 0, wr_excl = 0;
    logic [ID_W-1:0]   rd_id = '0, wr_id = '0;
    logic [ADDR_W-1:0] rd_addr = '0, wr_addr = '0;
    logic [SIZE_W-1:0] rd_size = '0, wr_size = '0;
    logic              wr_mem_en;
    logic [1:0]        wr_resp;

    int n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    excl_monitor #(.N_ENT(N_ENT), .ID_W(ID_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_id(rd_id), .rd_addr(rd_addr), .rd_size(rd_size), .rd_excl(rd_excl),
        .wr_valid(wr_valid), .wr_id(wr_id), .wr_addr(wr_addr), .wr_size(wr_size), .wr_excl(wr_excl),
        .wr_mem_en(wr_mem_en), .wr_resp(wr_resp)
    );

    task automatic check(input logic exp_en, input logic [1:0] exp_resp, input string tag);
        n_chk++;
        if (wr_mem_en !== exp_en || wr_resp !== exp_resp) begin
            n_err++;
            $display("FAIL %s: en=%0b resp=%0d expected en=%0b resp=%0d",
                     tag, wr_mem_en, wr_resp, exp_en, exp_resp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; rd_valid = 0; wr_valid = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic do_read(input int id, input int addr, input int sz, input logic ex);
        @(negedge clk);
        rd_valid = 1; rd_id = ID_W'(id); rd_addr = ADDR_W'(addr);
        rd_size = SIZE_W'(sz); rd_excl = ex;
        @(posedge clk); #1;
        rd_valid = 0;
    endtask

    task automatic do_write(input int id, input int addr, input int sz, input logic ex,
                            input logic exp_en, input logic [1:0] exp_resp, input string tag);
        @(negedge clk);
        wr_valid = 1; wr_id = ID_W'(id); wr_addr = ADDR_W'(addr);
        wr_size = SIZE_W'(sz); wr_excl = ex;
        #1;
        check(exp_en, exp_resp, tag);
        @(posedge clk); #1;
        wr_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: en=%0b resp=%0d expected completion", wr_mem_en, wr_resp);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();
        // R1 and R12: reset state, idle output
        @(negedge clk); #1; check(1'b0, 2'b00, "R12 idle");
        do_write(1, 'h100, 2, 1, 1'b0, 2'b00, "R1 no reservation after reset");

        // R2, R10: basic success, then repeat fails
        do_reset();
        do_read(1, 'h100, 2, 1);
        do_write(1, 'h100, 2, 1, 1'b1, 2'b01, "R2 matched exclusive write");
        do_write(1, 'h100, 2, 1, 1'b0, 2'b00, "R10 own entry freed");

        // R3: mismatched exclusive write fails and leaves entry intact
        do_reset();
        do_read(3, 'h700, 2, 1);
        do_write(3, 'h701, 0, 1, 1'b0, 2'b00, "R3 address mismatch fails");
        do_write(3, 'h700, 1, 1, 1'b0, 2'b00, "R3 size mismatch fails");
        do_write(4, 'h700, 2, 1, 1'b0, 2'b00, "R3 other id fails");
        do_write(3, 'h700, 2, 1, 1'b1, 2'b01, "R3 entry survived failures");

        // R4: success by one id kills other id's reservation
        do_reset();
        do_read(1, 'h600, 2, 1);
        do_read(2, 'h600, 2, 1);
        do_write(1, 'h600, 2, 1, 1'b1, 2'b01, "R4 first writer wins");
        do_write(2, 'h600, 2, 1, 1'b0, 2'b00, "R4 second writer loses");

        // R5: normal write commits and kills reservation
        do_reset();
        do_read(1, 'h200, 2, 1);
        do_write(2, 'h200, 2, 0, 1'b1, 2'b00, "R5 normal write commits");
        do_write(1, 'h200, 2, 1, 1'b0, 2'b00, "R5 reservation broken");

        // R6: replacement per id
        do_reset();
        do_read(2, 'h400, 2, 1);
        do_read(2, 'h500, 2, 1);
        do_write(2, 'h400, 2, 1, 1'b0, 2'b00, "R6 old address dropped");
        do_write(2, 'h500, 2, 1, 1'b1, 2'b01, "R6 new address held");

        // R7: all entries used by distinct ids
        do_reset();
        for (int i = 0; i < N_ENT; i++) do_read(i + 1, 'h1000 + i * 'h40, 3, 1);
        for (int i = 0; i < N_ENT; i++)
            do_write(i + 1, 'h1000 + i * 'h40, 3, 1, 1'b1, 2'b01, "R7 concurrent reservations");

        // R8: pool full, oldest reclaimed
        do_reset();
        for (int i = 0; i < N_ENT; i++) do_read(i + 1, 'h100 * (i + 1), 2, 1);
        do_read(9, 'h900, 2, 1);
        do_write(1, 'h100, 2, 1, 1'b0, 2'b00, "R8 oldest evicted");
        for (int i = 1; i < N_ENT; i++)
            do_write(i + 1, 'h100 * (i + 1), 2, 1, 1'b1, 2'b01, "R8 younger kept");
        do_write(9, 'h900, 2, 1, 1'b1, 2'b01, "R8 newcomer held");

        // R8: free slot preferred over eviction
        do_reset();
        for (int i = 0; i < N_ENT; i++) do_read(i + 1, 'h100 * (i + 1), 2, 1);
        do_write(7, 'h300, 2, 0, 1'b1, 2'b00, "R5 clearing write");
        do_read(9, 'h900, 2, 1);
        do_write(1, 'h100, 2, 1, 1'b1, 2'b01, "R8 free slot used, oldest kept");
        do_write(9, 'h900, 2, 1, 1'b1, 2'b01, "R8 newcomer in free slot");

        // R8: replacement refreshes age
        do_reset();
        for (int i = 0; i < N_ENT; i++) do_read(i + 1, 'h100 * (i + 1), 2, 1);
        do_read(1, 'h180, 2, 1);
        do_read(9, 'h900, 2, 1);
        do_write(2, 'h200, 2, 1, 1'b0, 2'b00, "R8 next-oldest evicted");
        do_write(1, 'h180, 2, 1, 1'b1, 2'b01, "R8 refreshed entry kept");

        // R9: sweep write offsets around a 4-byte reservation at 0x100
        for (int a = 'hF8; a <= 'h107; a++) begin
            bit hit;
            do_reset();
            hit = ((a + 2) > 'h100) && (a < 'h104);
            do_read(1, 'h100, 2, 1);
            do_write(2, a, 1, 0, 1'b1, 2'b00, "R9 normal write");
            do_write(1, 'h100, 2, 1, !hit, hit ? 2'b00 : 2'b01, "R9 overlap sweep");
        end

        // R11: allocation and clearing write in the same cycle
        do_reset();
        do_read(1, 'h800, 2, 1);
        @(negedge clk);
        rd_valid = 1; rd_id = 2; rd_addr = 'h800; rd_size = 2; rd_excl = 1;
        wr_valid = 1; wr_id = 3; wr_addr = 'h800; wr_size = 2; wr_excl = 0;
        #1; check(1'b1, 2'b00, "R11 simultaneous normal write");
        @(posedge clk); #1;
        rd_valid = 0; wr_valid = 0;
        do_write(1, 'h800, 2, 1, 1'b0, 2'b00, "R11 older reservation cleared");
        do_write(2, 'h800, 2, 1, 1'b1, 2'b01, "R11 new reservation kept");

        // R12: non-exclusive read allocates nothing
        do_reset();
        do_read(5, 'h300, 2, 0);
        do_write(5, 'h300, 2, 1, 1'b0, 2'b00, "R12 plain read no reservation");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule